// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a small set of sticky flags that tell software which reset sources have fired since it last cleared them. Five single-cycle event inputs feed it: power-on, the external reset pin, brown-out detection, the watchdog, and a reset requested through the debug port's reset register. Each event raises its own flag. The flag stays set until software writes a zero to that bit. A power-on event is special: it sets its own flag and wipes all the others, so the register reads 0x01 after a cold start.

Software reaches the register over a simple peripheral bus with an address, a read strobe, a write strobe, 8-bit write data and 8-bit read data. The register answers at two addresses. One is the load/store data-space offset. The other is a short I/O-space offset that sits 0x20 lower. A usual boot routine reads the register early, notes the cause, and writes zeros so that the next read shows only the causes that came later. The register's own storage is cleared only by its power-on path and by `rst_n`. The resets it records do not clear it.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst_n` is released, the register reads 0x00. Flag layout: bit 0 power-on, bit 1 external, bit 2 brown-out, bit 3 watchdog, bit 4 debug-port reset.
- R2: A write stores `flags & wdata[4:0]` in the next cycle. A 0 clears the matching flag and a 1 leaves it unchanged, so one write can clear any subset of flags.
- R3: One cycle after an `ev_por` pulse, the register reads 0x01. This holds whatever other events or writes happen in the same cycle.
- R4: A pulse on `ev_ext`, `ev_bod`, `ev_wdt` or `ev_dbg` sets bit 1, 2, 3 or 4 in the next cycle. A set flag stays set until it is cleared by a write of 0 or by a power-on event.
- R5: When an event and a write of 0 to the same bit happen in the same cycle, the flag ends up set.
- R6: The register is decoded for reads and writes at address 0x54 and at address 0x34 (0x54 minus 0x20), and behaves the same at both.
- R7: A read at any other address returns 0x00. A write at any other address leaves the flags unchanged.
- R8: Bits 7 to 5 always read 0, and writing 1s to them changes nothing.
- R9: Bit 0 is cleared only by a write of 0. Non-power-on events and writes of 1 leave it as it is.
- R10: Read data is combinational. While `bus_rd` is high and the address decodes, `bus_rdata` shows the current flags. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low initialization of the flag storage |
| ev_por | input | 1 | Power-on event pulse |
| ev_ext | input | 1 | External reset event pulse |
| ev_bod | input | 1 | Brown-out event pulse |
| ev_wdt | input | 1 | Watchdog reset event pulse |
| ev_dbg | input | 1 | Debug-port reset-register event pulse |
| bus_addr | input | 8 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |

## Verification
The bench brings the register to each of the 32 flag combinations and, from each one, applies 32 clear masks at both decoded addresses. Each mask also carries varying upper-bit patterns. This separates a correct AND-with-data clear from inverted-polarity, set-on-one and address-specific faults. A sweep over all 256 addresses, done with every flag set, catches stray decodes on both the read side and the write side. Directed cycles then put an event and a clearing write in the same cycle, and put a power-on event together with other events. These cycles show whether the set beats the clear and whether power-on wipes every other flag.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] MEM_ADDR = 8'h54,
  parameter logic [AW-1:0] IO_SHIFT = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_por,
  input  logic          ev_ext,
  input  logic          ev_bod,
  input  logic          ev_wdt,
  input  logic          ev_dbg,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int NF = 5;
  localparam logic [AW-1:0] IO_ADDR = MEM_ADDR - IO_SHIFT;

  logic [NF-1:0] flags, nxt, keep, ev;
  logic hit;

  assign hit  = (bus_addr == MEM_ADDR) || (bus_addr == IO_ADDR);
  assign ev   = {ev_dbg, ev_wdt, ev_bod, ev_ext, 1'b0};
  assign keep = (bus_wr && hit) ? bus_wdata[NF-1:0] : '1;
  assign nxt  = ev_por ? NF'(1) : ((flags & keep) | ev);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= nxt;

  assign bus_rdata = (bus_rd && hit) ? {{(DW-NF){1'b0}}, flags} : '0;

  // R3: power-on leaves only its own flag
  p_por_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> (bus_rd && hit) -> (bus_rdata == DW'(1)));
  p_por_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_por |=> flags == NF'(1));
  // R4: flags are sticky without a write or power-on
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_por && !(bus_wr && hit)) |=> ((flags & $past(flags)) == $past(flags)));
  // R5: event beats a same-cycle clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wdt && !ev_por && bus_wr && hit && !bus_wdata[3]) |=> flags[3]);
  // R7: stray writes do nothing
  p_miss_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit && !ev_por && !ev_ext && !ev_bod && !ev_wdt && !ev_dbg)
      |=> $stable(flags));
  // R8: upper bits never driven
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NF] == '0);
  // R9: power-on flag only falls through a write
  p_por_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(bus_wr && hit && !bus_wdata[0]));
endmodule

// File: tb/sim_rst_cause_reg.sv
module sim_rst_cause_reg;
  localparam int CLK_PER = 10;
  localparam logic [7:0] A_MEM = 8'h54, A_IO = 8'h34;

  logic clk = 0, rst_n = 0;
  logic ev_por = 0, ev_ext = 0, ev_bod = 0, ev_wdt = 0, ev_dbg = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_rd = 0, bus_wr = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  rst_cause_reg u0 (.clk, .rst_n, .ev_por, .ev_ext, .ev_bod, .ev_wdt, .ev_dbg,
                    .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    {ev_dbg, ev_wdt, ev_bod, ev_ext, ev_por} = m;
    @(negedge clk);
    {ev_dbg, ev_wdt, ev_bod, ev_ext, ev_por} = '0;
  endtask

  task automatic set_state(input logic [4:0] v);
    logic [7:0] d;
    pulse(5'b00001);
    if (v[4:1] != 0) pulse({v[4:1], 1'b0});
    if (!v[0]) wr(A_MEM, 8'hFE);
    rd(A_IO, d);
    chk("R4 setup", d, {3'b0, v});
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rd(A_MEM, d); chk("R1 reset", d, 8'h00);
    rst_n = 1;
    rd(A_MEM, d); chk("R1 after release", d, 8'h00);
    rd(A_IO, d);  chk("R1 io after release", d, 8'h00);

    pulse(5'b00001); rd(A_MEM, d); chk("R3 por alone", d, 8'h01);
    pulse(5'b00010); rd(A_MEM, d); chk("R4 ext bit1", d, 8'h03);
    pulse(5'b00100); rd(A_MEM, d); chk("R4 bod bit2", d, 8'h07);
    pulse(5'b01000); rd(A_MEM, d); chk("R4 wdt bit3", d, 8'h0F);
    pulse(5'b10000); rd(A_MEM, d); chk("R4 dbg bit4", d, 8'h1F);
    repeat (5) @(negedge clk);
    rd(A_IO, d); chk("R4 hold", d, 8'h1F);
    pulse(5'b11111); rd(A_MEM, d); chk("R3 por with all events", d, 8'h01);

    // R9: bit0 untouched by events and by writing 1
    pulse(5'b11110); wr(A_MEM, 8'hE1); rd(A_MEM, d); chk("R9 bit0 kept", d, 8'h01);
    wr(A_IO, 8'hFE); rd(A_MEM, d); chk("R9 bit0 write-zero", d, 8'h00);

    // R3 with a write in the same cycle
    @(negedge clk); bus_addr = A_MEM; bus_wr = 1; bus_wdata = 8'h00; ev_por = 1; ev_bod = 1;
    @(negedge clk); bus_wr = 0; ev_por = 0; ev_bod = 0;
    rd(A_MEM, d); chk("R3 por beats write", d, 8'h01);

    // R5: each event against a same-cycle clear
    for (int b = 1; b < 5; b++) begin
      set_state(5'b00000);
      @(negedge clk); bus_addr = (b[0] ? A_IO : A_MEM); bus_wr = 1; bus_wdata = 8'h00;
      {ev_dbg, ev_wdt, ev_bod, ev_ext} = 4'(1 << (b-1));
      @(negedge clk); bus_wr = 0; {ev_dbg, ev_wdt, ev_bod, ev_ext} = '0;
      rd(A_MEM, d); chk("R5 set wins", d, 8'(1 << b));
    end

    // R2/R6/R8: every state x every mask at both addresses
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 32; w++)
        for (int ai = 0; ai < 2; ai++) begin
          set_state(5'(s));
          wr(ai ? A_IO : A_MEM, {3'((s + w) % 8), 5'(w)});
          rd(ai ? A_MEM : A_IO, d);
          chk(ai ? "R2/R6 io write" : "R2/R8 mem write", d, 8'(s & w));
        end

    // R7/R10: address sweep
    set_state(5'h1F);
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), d);
      chk("R7/R10 read sweep", d, (8'(a) == A_MEM || 8'(a) == A_IO) ? 8'h1F : 8'h00);
      if (8'(a) != A_MEM && 8'(a) != A_IO) wr(8'(a), 8'h00);
    end
    rd(A_MEM, d); chk("R7 stray writes ignored", d, 8'h1F);
    @(negedge clk); bus_addr = A_MEM; bus_rd = 0;
    #1 chk("R10 idle read zero", bus_rdata, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule